// File: doc/BRIEF.md
# Signed-by-Unsigned Iterative Divider

This block is the divide unit of a small microcode engine. It takes a signed 48-bit dividend and an unsigned 16-bit divisor and produces a signed 48-bit quotient. The quotient is rounded toward zero. Its sign follows the sign of the dividend.

A pulse on `start` while the unit is idle captures both operands. The unit then finds the dividend's magnitude in a setup cycle and runs one restoring shift-subtract step per clock for all 48 dividend bits. A final cycle restores the sign. `busy` covers the whole operation. `done` pulses once in the cycle the new quotient appears. A zero divisor skips the iteration: the quotient becomes all ones (-1) one cycle after `start`, and `busy` never rises.

The engine is expected to wait for `done` before it issues another divide. A `start` that arrives while the unit is busy is dropped. The quotient register keeps the last result until the next operation completes.

Top module: `mdiv_core`

## Requirements
- R1: For a non-zero divisor, the quotient equals the signed 48-bit dividend divided by the divisor, rounded toward zero. The quotient is negative only when the dividend is negative and the magnitude of the result is non-zero.
- R2: When `start` is sampled while idle with `divisor` = 0, `quotient` is 48'hFFFF_FFFF_FFFF and `done` is high in the next cycle. `busy` stays low.
- R3: When `start` is sampled while idle with a non-zero divisor, `busy` is high for exactly 50 cycles starting with the next cycle. `done` and the new quotient appear in the cycle in which `busy` falls, 50 clock edges after the start edge.
- R4: `done` is high for one cycle per completed operation and is never high together with `busy`.
- R5: While `busy` is high, `start` has no effect, and changes on `dividend` and `divisor` do not change the result. The operands are the ones present at the accepted start edge.
- R6: `quotient` changes only in a cycle where `done` is high. Otherwise it holds its value.
- R7: While `rst_n` is low at a clock edge, `busy`, `done` and `quotient` are cleared to zero.
- R8: The most negative dividend (-2^47) is handled without overflow. Divided by 1 it gives -2^47, and the largest positive dividend divided by 1 gives itself.
- R9: The divisor is unsigned over all 16 bits, so a divisor with bit 15 set (for example 16'hFFFF = 65535) divides as a large positive value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a divide; accepted only while idle |
| dividend | input | 48 | Signed dividend, sampled at an accepted start |
| divisor | input | 16 | Unsigned divisor, sampled at an accepted start |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: quotient updated |
| quotient | output | 48 | Signed quotient of the last completed operation |

## Verification
Most internal faults appear only at the end of an operation, so the bench compares busy, done and quotient against a behavioural model on every clock. If the iteration count is wrong, `busy` falls early or late, and this shows within the 50-cycle window. A wrong subtract decision or a bad sign fix shows as a wrong quotient in the `done` cycle. For this reason the operands include negative values, the most negative dividend, divisors with bit 15 set, and small dividends that round toward zero. Starts and operand changes while busy catch a unit that recaptures its inputs, and back-to-back zero divides check the one-cycle bypass.

// File: rtl/mdiv_pkg.sv
// Package mdiv_pkg
// Shared types for the iterative divider: the sequencer state encoding.
// Assumes nothing beyond being compiled before the other divider files.
package mdiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_ITER  = 2'd2,
        ST_FIX   = 2'd3
    } mdiv_state_t;

endpackage

// File: rtl/mdiv_step.sv
// Module mdiv_step
// One restoring shift-subtract step, purely combinational.
// It shifts the top bit of the working dividend into the partial remainder.
// It subtracts the divisor when it fits and shifts the result bit into the
// low end of the working word.
// Assumes rem_i < den_i on entry (true from a cleared remainder), so the new
// remainder also fits in DW bits.
module mdiv_step #(
    parameter int NW = 48,
    parameter int DW = 16
) (
    input  logic [DW-1:0] rem_i,
    input  logic [NW-1:0] work_i,
    input  logic [DW-1:0] den_i,
    output logic [DW-1:0] rem_o,
    output logic [NW-1:0] work_o
);
    logic [DW:0] shifted;
    logic [DW:0] trial;
    logic        fits;

    // Purpose: form the shifted remainder, the trial difference and the quotient bit.
    always_comb begin
        shifted = {rem_i, work_i[NW-1]};
        fits    = (shifted >= {1'b0, den_i});
        trial   = shifted - {1'b0, den_i};
        rem_o   = DW'(fits ? trial : shifted);
        work_o  = {work_i[NW-2:0], fits};
    end

endmodule

// File: rtl/mdiv_ctrl.sv
// Module mdiv_ctrl
// Sequencer for the divider: idle -> setup -> NW iteration cycles -> sign fix.
// It accepts start only while idle. A zero divisor is finished straight from
// idle. done is registered and lasts one cycle per operation.
// Assumes den_zero describes the divisor presented with start.
module mdiv_ctrl
    import mdiv_pkg::*;
#(
    parameter int NW = 48
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic den_zero,
    output logic cap_o,
    output logic setup_o,
    output logic step_o,
    output logic fix_o,
    output logic zload_o,
    output logic busy_o,
    output logic done_o
);
    localparam int CNT_W = $clog2(NW + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NW - 1);

    mdiv_state_t      state;
    logic [CNT_W-1:0] iter_cnt;
    logic             done_r;

    // Purpose: decode per-cycle datapath strobes from the current state.
    always_comb begin
        cap_o   = (state == ST_IDLE) && start && !den_zero;
        zload_o = (state == ST_IDLE) && start &&  den_zero;
        setup_o = (state == ST_SETUP);
        step_o  = (state == ST_ITER);
        fix_o   = (state == ST_FIX);
    end

    // Purpose: advance the sequencer and count iteration cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            iter_cnt <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (cap_o) state <= ST_SETUP;
                end
                ST_SETUP: begin
                    iter_cnt <= '0;
                    state    <= ST_ITER;
                end
                ST_ITER: begin
                    iter_cnt <= iter_cnt + 1'b1;
                    if (iter_cnt == LAST) state <= ST_FIX;
                end
                ST_FIX: begin
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Purpose: register the completion pulse for both the iterative and zero paths.
    always_ff @(posedge clk) begin
        if (!rst_n) done_r <= 1'b0;
        else        done_r <= fix_o || zload_o;
    end

    assign busy_o = (state != ST_IDLE);
    assign done_o = done_r;

endmodule

// File: rtl/mdiv_datapath.sv
// Module mdiv_datapath
// Operand capture, magnitude, iteration and sign fix for the divider.
// It holds the raw operands from the accepted start. Setup converts the
// dividend to a magnitude, and each step strobe runs one mdiv_step. Fix
// applies the saved sign to the result. The result register also takes -1
// for a zero divisor.
// Assumes the strobes are mutually exclusive (guaranteed by mdiv_ctrl).
module mdiv_datapath #(
    parameter int NW = 48,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_i,
    input  logic          setup_i,
    input  logic          step_i,
    input  logic          fix_i,
    input  logic          zload_i,
    input  logic [NW-1:0] dividend_i,
    input  logic [DW-1:0] divisor_i,
    output logic [NW-1:0] quotient_o
);
    logic [NW-1:0] num_raw;
    logic [DW-1:0] den_reg;
    logic          neg_reg;
    logic [DW-1:0] rem_reg;
    logic [NW-1:0] work_reg;
    logic [DW-1:0] rem_nxt;
    logic [NW-1:0] work_nxt;
    logic [NW-1:0] q_reg;

    mdiv_step #(.NW(NW), .DW(DW)) u_step (
        .rem_i  (rem_reg),
        .work_i (work_reg),
        .den_i  (den_reg),
        .rem_o  (rem_nxt),
        .work_o (work_nxt)
    );

    // Purpose: capture the operands at an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            num_raw <= '0;
            den_reg <= '0;
        end else if (cap_i) begin
            num_raw <= dividend_i;
            den_reg <= divisor_i;
        end
    end

    // Purpose: form the magnitude in setup, then iterate one bit per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            neg_reg  <= 1'b0;
            rem_reg  <= '0;
            work_reg <= '0;
        end else if (setup_i) begin
            neg_reg  <= num_raw[NW-1];
            rem_reg  <= '0;
            work_reg <= num_raw[NW-1] ? (~num_raw + 1'b1) : num_raw;
        end else if (step_i) begin
            rem_reg  <= rem_nxt;
            work_reg <= work_nxt;
        end
    end

    // Purpose: load the signed result, or all ones for a zero divisor.
    always_ff @(posedge clk) begin
        if (!rst_n)       q_reg <= '0;
        else if (zload_i) q_reg <= '1;
        else if (fix_i)   q_reg <= neg_reg ? (~work_reg + 1'b1) : work_reg;
    end

    assign quotient_o = q_reg;

endmodule

// File: rtl/mdiv_core.sv
// Module mdiv_core
// Top of the signed 48-bit by unsigned 16-bit iterative divider.
// A non-zero divide takes a setup cycle, NW iteration cycles and a sign-fix
// cycle. A zero divisor returns -1 one cycle after start.
// Assumes start is ignored by design while busy and the caller waits for done.
module mdiv_core #(
    parameter int NW = 48,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [NW-1:0] dividend,
    input  logic [DW-1:0] divisor,
    output logic          busy,
    output logic          done,
    output logic [NW-1:0] quotient
);
    logic cap_s, setup_s, step_s, fix_s, zload_s;
    logic den_zero;

    // Purpose: flag a zero divisor for the bypass path.
    always_comb den_zero = (divisor == '0);

    mdiv_ctrl #(.NW(NW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .den_zero (den_zero),
        .cap_o    (cap_s),
        .setup_o  (setup_s),
        .step_o   (step_s),
        .fix_o    (fix_s),
        .zload_o  (zload_s),
        .busy_o   (busy),
        .done_o   (done)
    );

    mdiv_datapath #(.NW(NW), .DW(DW)) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_i      (cap_s),
        .setup_i    (setup_s),
        .step_i     (step_s),
        .fix_i      (fix_s),
        .zload_i    (zload_s),
        .dividend_i (dividend),
        .divisor_i  (divisor),
        .quotient_o (quotient)
    );

endmodule

// File: rtl/mdiv_chk.sv
// Module mdiv_chk
// Assertion checker for mdiv_core, attached by bind. It watches only the
// top-level ports and counts busy cycles itself.
// Assumes synchronous active-low reset.
module mdiv_chk #(
    parameter int NW = 48,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [DW-1:0] divisor,
    input logic          busy,
    input logic          done,
    input logic [NW-1:0] quotient
);
    localparam int LAT = NW + 2;
    localparam int CW  = $clog2(LAT + 2) + 1;

    logic          primed;
    logic [CW-1:0] busy_run;

    // Purpose: mark that at least one clock has passed since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    // Purpose: count consecutive busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_run <= '0;
        else if (busy) busy_run <= busy_run + 1'b1;
        else           busy_run <= '0;
    end

    // R2: zero divisor answers -1 next cycle without going busy
    assert_zero_div_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && start && !busy && divisor == '0) |=> (done && !busy && quotient == '1));

    // R3: an accepted non-zero start raises busy next cycle
    assert_busy_after_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && start && !busy && divisor != '0) |=> busy);

    // R3, R5: busy lasts exactly LAT cycles, so a start while busy cannot restart it
    assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $fell(busy)) |-> (busy_run == CW'(LAT) && done));

    // R5: busy never exceeds the fixed window
    assert_no_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_run < CW'(LAT)));

    // R4: done never overlaps busy
    assert_done_not_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R6: the quotient only moves together with done
    assert_quot_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && !done) |-> $stable(quotient));

endmodule

bind mdiv_core mdiv_chk #(.NW(NW), .DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .divisor  (divisor),
    .busy     (busy),
    .done     (done),
    .quotient (quotient)
);

// File: tb/mdiv_core_tb.sv
`timescale 1ns/1ps
module mdiv_core_tb;
    localparam int NW  = 48;
    localparam int DW  = 16;
    localparam int LAT = NW + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [NW-1:0] dividend = '0;
    logic [DW-1:0] divisor = '0;
    logic          busy, done;
    logic [NW-1:0] quotient;

    int    n_tests = 0;
    int    n_fail  = 0;
    string cur_tag = "R7";

    // reference model state
    int            m_left = 0;
    logic          m_busy = 1'b0;
    logic          m_done = 1'b0;
    logic [NW-1:0] m_q = '0;
    logic [NW-1:0] m_pend = '0;

    always #2.5 clk = ~clk;

    mdiv_core #(.NW(NW), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
        .divisor(divisor), .busy(busy), .done(done), .quotient(quotient)
    );

    function automatic logic [NW-1:0] ref_div(input logic [NW-1:0] a, input logic [DW-1:0] b);
        longint sa, sb, q;
        sa = longint'(signed'(a));
        sb = longint'({1'b0, b});
        if (sb == 0) return '1;
        q = sa / sb;
        return q[NW-1:0];
    endfunction

    // behavioural model, updated on the same edge as the design
    always @(posedge clk) begin
        if (!rst_n) begin
            m_left = 0; m_busy = 0; m_done = 0; m_q = '0;
        end else begin
            m_done = 0;
            if (m_left > 0) begin
                m_left = m_left - 1;
                if (m_left == 0) begin
                    m_busy = 0; m_done = 1; m_q = m_pend;
                end
            end else if (start) begin
                if (divisor == '0) begin
                    m_done = 1; m_q = '1;
                end else begin
                    m_busy = 1; m_left = LAT; m_pend = ref_div(dividend, divisor);
                end
            end
        end
    end

    task automatic check1(input logic ok, input string what, input logic [NW-1:0] act, input logic [NW-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s act=%h exp=%h at %0t", cur_tag, what, act, exp, $time);
        end
    endtask

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check1(busy == m_busy, "busy (R3/R5)", NW'(busy), NW'(m_busy));
            check1(done == m_done, "done (R4)", NW'(done), NW'(m_done));
            check1(quotient == m_q, "quotient (R1/R6)", quotient, m_q);
        end
    end

    task automatic wait_idle();
        while (m_left != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run_op(input logic [NW-1:0] a, input logic [DW-1:0] b, input string tag);
        @(negedge clk);
        cur_tag = tag; dividend = a; divisor = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_idle();
    endtask

    // R5: start and operand changes while busy
    task automatic run_disturbed(input logic [NW-1:0] a, input logic [DW-1:0] b);
        @(negedge clk);
        cur_tag = "R5"; dividend = a; divisor = b; start = 1'b1;
        for (int i = 0; i < LAT - 2; i++) begin
            @(negedge clk);
            start    = i[0];
            dividend = a ^ NW'(i * 977);
            divisor  = (i % 5 == 0) ? '0 : DW'(i + 3);
        end
        @(negedge clk);
        start = 1'b0;
        wait_idle();
    endtask

    initial begin
        logic [31:0] lcg;
        logic [NW-1:0] ra;
        logic [DW-1:0] rb;
        repeat (3) @(negedge clk);
        cur_tag = "R7";
        check1(busy == 1'b0, "reset busy", NW'(busy), '0);
        check1(done == 1'b0, "reset done", NW'(done), '0);
        check1(quotient == '0, "reset quotient", quotient, '0);
        rst_n = 1'b1;

        run_op(48'd100, 16'd7, "R1");
        run_op(-48'sd100, 16'd7, "R1");
        run_op(48'd7, 16'd100, "R1");
        run_op(-48'sd7, 16'd100, "R1");
        run_op(48'h7FFF_FFFF_FFFF, 16'd3, "R1");
        run_op(48'd12345, 16'd0, "R2");
        run_op(-48'sd5, 16'd0, "R2");
        // R2: back-to-back zero divides
        @(negedge clk); cur_tag = "R2"; divisor = '0; dividend = 48'd9; start = 1'b1;
        @(negedge clk); @(negedge clk); start = 1'b0;
        wait_idle();
        run_op(48'h8000_0000_0000, 16'd1, "R8");
        run_op(48'h7FFF_FFFF_FFFF, 16'd1, "R8");
        run_op(48'h8000_0000_0000, 16'hFFFF, "R8");
        run_op(48'd1000000, 16'h8000, "R9");
        run_op(-48'sd1000000, 16'hFFFF, "R9");
        run_disturbed(48'd987654321, 16'd321);
        run_disturbed(-48'sd55555, 16'hC000);
        // R6: idle cycles with inputs moving but no start
        @(negedge clk); cur_tag = "R6"; dividend = 48'd77; divisor = 16'd0;
        repeat (5) @(negedge clk);
        lcg = 32'h1234_5678;
        for (int k = 0; k < 40; k++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            ra[31:0] = lcg;
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            ra[NW-1:32] = lcg[15:0];
            rb = (k % 3 == 0) ? DW'(lcg[31:28]) : lcg[31:16];
            run_op(ra, rb, "R1");
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL R3 watchdog expired act=hung exp=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule